// File: doc/BRIEF.md
# FIFO Status and Interrupt Unit

This block holds a pair of byte-wide FIFOs for a serial transceiver: a transmit FIFO that the processor fills and the serial engine drains, and a receive FIFO that the serial engine fills and the processor drains. Both FIFOs have the same power-of-two depth, given by a parameter, with a minimum of 1. The block turns the fill levels into read-only flags in a 32-bit control word. The same word reports the depth as its base-2 logarithm.

The block also drives a single interrupt request. Three fill conditions can each be enabled on their own: receive FIFO not empty, transmit FIFO empty, and transmit FIFO below half full. The enabled conditions are OR-ed together. The request is a level, not a pulse: it stays high for as long as an enabled condition holds.

A small run/stop state machine takes its input from the enable bit of the control word. Writing the enable bit as 0 moves the machine to `ST_OFF`, which empties both FIFOs. Writing it as 1 moves the machine to `ST_RUN`. The processor's own pending-interrupt register is outside this block.

Top module: `fifo_stat_irq`

## Requirements
- R1: After reset the state is `ST_OFF`, both FIFOs are empty, all interrupt enables are 0, `irq_o` is 0, and `ctrl_rdata_o` shows only the depth field, bit 16 and bit 17.
- R2: Bit 15 of `ctrl_rdata_o` is 1 when the receive FIFO holds at least one byte. Bit 16 is 1 when the transmit FIFO is empty.
- R3: Bit 17 of `ctrl_rdata_o` is 1 when the transmit FIFO count is below DEPTH/2. For DEPTH = 1 this means the FIFO is empty.
- R4: Bit 18 of `ctrl_rdata_o` is 1 when the transmit FIFO holds DEPTH bytes. A push into a full transmit FIFO is dropped, even if a take happens in the same cycle.
- R5: Bits 26:23 of `ctrl_rdata_o` read log2(DEPTH). Bit 0 and bits 21:19 read back the last written value. All other bits read 0.
- R6: `irq_o` is the OR of three terms: bit 19 AND receive-not-empty, bit 20 AND transmit-empty, and bit 21 AND transmit-below-half. `irq_o` stays high while any enabled term holds and falls once the cause is removed.
- R7: `rx_data_o` shows the oldest received byte. When the receive FIFO is empty it shows 0, and a pop leaves the state unchanged.
- R8: A byte offered on `eng_rx_valid_i` while the receive FIFO is full is discarded, even if a pop happens in the same cycle.
- R9: `eng_tx_valid_o` is 1 in `ST_RUN` when the transmit FIFO is not empty. `eng_tx_data_o` then shows the oldest byte. `eng_tx_take_i` removes bytes in the order they were written.
- R10: A control write with bit 0 = 0 empties both FIFOs at that same clock edge. In `ST_OFF`, pushes, pops and arriving bytes have no effect and `irq_o` is 0.
- R11: Transition RUN_GO (`ST_OFF` to `ST_RUN`) happens on a control write with bit 0 = 1. Transition STOP (`ST_RUN` to `ST_OFF`) happens on a control write with bit 0 = 0. FIFO traffic in the cycle of the RUN_GO write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 32 | Control write data (bit 0 run, bits 21:19 interrupt enables) |
| ctrl_rdata_o | output | 32 | Control/status word |
| tx_push_i | input | 1 | Processor writes a byte to the transmit FIFO |
| tx_data_i | input | 8 | Byte to transmit |
| rx_pop_i | input | 1 | Processor removes the oldest received byte |
| rx_data_o | output | 8 | Oldest received byte, or 0 when empty |
| eng_tx_valid_o | output | 1 | Transmit byte available to the serial engine |
| eng_tx_data_o | output | 8 | Oldest transmit byte |
| eng_tx_take_i | input | 1 | Serial engine consumes the oldest transmit byte |
| eng_rx_valid_i | input | 1 | Serial engine delivers a received byte |
| eng_rx_data_i | input | 8 | Received byte |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench targets these corner cases:
- A push into a full transmit FIFO in the same cycle as a take. A design that lets it in would reorder or duplicate bytes.
- A receive arrival while the FIFO is full. If it is not discarded, it overwrites the oldest byte.
- A pop from an empty receive FIFO. It must read 0 and not wrap the pointers.
- The half-full threshold, checked at counts one below and exactly at DEPTH/2. An off-by-one compare moves the edge of the interrupt.
- Disabling with data in both FIFOs, and traffic on the very cycle of enabling. A late flush would leave stale bytes readable, and an early accept would let a byte in before the block runs.
- The interrupt is held over idle cycles, to show it is a level and not a one-cycle pulse.

// File: rtl/fsi_pkg.sv
package fsi_pkg;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } run_state_e;

    // Control word bit positions read by the software driver
    localparam int unsigned BIT_RUN      = 0;
    localparam int unsigned BIT_RX_AVAIL = 15;
    localparam int unsigned BIT_TX_EMPTY = 16;
    localparam int unsigned BIT_TX_BHALF = 17;
    localparam int unsigned BIT_TX_FULL  = 18;
    localparam int unsigned BIT_IE_LSB   = 19;
    localparam int unsigned IE_W         = 3;
    localparam int unsigned DEPTH_LSB    = 23;
    localparam int unsigned DEPTH_FLD_W  = 4;

    typedef struct packed {
        logic tx_full;
        logic tx_below_half;
        logic tx_empty;
        logic rx_avail;
    } fifo_flags_t;

    // bit order matches control bits 21:19
    typedef struct packed {
        logic tx_below_half;
        logic tx_empty;
        logic rx_avail;
    } irq_en_t;

endpackage

// File: rtl/fsi_fifo.sv
module fsi_fifo #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned WIDTH = 8,
    localparam int unsigned CW   = $clog2(DEPTH) + 1,
    localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             push_i,
    input  logic [WIDTH-1:0] din_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] head_o,
    output logic [CW-1:0]    count_o
);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PW-1:0]    wr_ptr_q, rd_ptr_q;
    logic [CW-1:0]    cnt_q;
    logic             do_push, do_pop;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        if (p == PW'(DEPTH - 1)) return '0;
        else                     return p + PW'(1);
    endfunction

    // a full FIFO refuses the push even when a pop happens in the same cycle
    assign do_push = push_i && (cnt_q != CW'(DEPTH));
    assign do_pop  = pop_i  && (cnt_q != '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else if (clr_i) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (do_push) wr_ptr_q <= ptr_next(wr_ptr_q);
            if (do_pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk_i) begin
        if (do_push && !clr_i) mem_q[wr_ptr_q] <= din_i;
    end

    assign head_o  = (cnt_q != '0) ? mem_q[rd_ptr_q] : '0;
    assign count_o = cnt_q;

endmodule

// File: rtl/fsi_flags.sv
module fsi_flags
    import fsi_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
    input  logic [CW-1:0] tx_count_i,
    input  logic [CW-1:0] rx_count_i,
    output fifo_flags_t   flags_o
);

    assign flags_o.rx_avail = (rx_count_i != '0);
    assign flags_o.tx_empty = (tx_count_i == '0);
    assign flags_o.tx_full  = (tx_count_i == CW'(DEPTH));

    generate
        if (DEPTH == 1) begin : g_single
            // half of one entry: reaching it means holding anything
            assign flags_o.tx_below_half = (tx_count_i == '0);
        end else begin : g_multi
            localparam int unsigned HALF = DEPTH / 2;
            assign flags_o.tx_below_half = (tx_count_i < CW'(HALF));
        end
    endgenerate

endmodule

// File: rtl/fsi_ctrl_fsm.sv
module fsi_ctrl_fsm
    import fsi_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       ctrl_we_i,
    input  logic       run_wr_i,
    input  irq_en_t    ie_wr_i,
    output run_state_e state_o,
    output logic       flush_o,
    output logic       accept_o,
    output irq_en_t    ie_o
);

    run_state_e state_q, state_d;
    irq_en_t    ie_q;

    // next-state: RUN_GO and STOP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (ctrl_we_i && run_wr_i)  state_d = ST_RUN;
            ST_RUN: if (ctrl_we_i && !run_wr_i) state_d = ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_OFF;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        ie_q <= '0;
        else if (ctrl_we_i) ie_q <= ie_wr_i;
    end

    // outputs: flush whenever the coming state is OFF, accept only across RUN->RUN
    always_comb begin
        flush_o  = 1'b0;
        accept_o = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                flush_o  = 1'b1;
                accept_o = 1'b0;
            end
            ST_RUN: begin
                flush_o  = (state_d == ST_OFF);
                accept_o = (state_d == ST_RUN);
            end
            default: begin
                flush_o  = 1'b1;
                accept_o = 1'b0;
            end
        endcase
    end

    assign state_o = state_q;
    assign ie_o    = ie_q;

endmodule

// File: rtl/fsi_irq.sv
module fsi_irq
    import fsi_pkg::*;
(
    input  logic        run_i,
    input  irq_en_t     ie_i,
    input  fifo_flags_t flags_i,
    output logic        irq_o
);

    logic [IE_W-1:0] cause;

    assign cause[0] = ie_i.rx_avail      && flags_i.rx_avail;
    assign cause[1] = ie_i.tx_empty      && flags_i.tx_empty;
    assign cause[2] = ie_i.tx_below_half && flags_i.tx_below_half;

    assign irq_o = run_i && (|cause);

endmodule

// File: rtl/fifo_stat_irq.sv
module fifo_stat_irq
    import fsi_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned DW    = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          ctrl_we_i,
    input  logic [31:0]   ctrl_wdata_i,
    output logic [31:0]   ctrl_rdata_o,
    input  logic          tx_push_i,
    input  logic [DW-1:0] tx_data_i,
    input  logic          rx_pop_i,
    output logic [DW-1:0] rx_data_o,
    output logic          eng_tx_valid_o,
    output logic [DW-1:0] eng_tx_data_o,
    input  logic          eng_tx_take_i,
    input  logic          eng_rx_valid_i,
    input  logic [DW-1:0] eng_rx_data_i,
    output logic          irq_o
);

    localparam int unsigned CW = $clog2(DEPTH) + 1;
    localparam logic [DEPTH_FLD_W-1:0] DEPTH_LOG = DEPTH_FLD_W'($clog2(DEPTH));

    run_state_e  state;
    logic        flush, accept, run;
    irq_en_t     ie, ie_wr;
    fifo_flags_t flags;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic [DW-1:0] tx_head, rx_head;
    logic        unused_wdata_bits;

    assign unused_wdata_bits = ^{ctrl_wdata_i[31:22], ctrl_wdata_i[18:1]};
    assign ie_wr = ctrl_wdata_i[BIT_IE_LSB +: IE_W];

    fsi_ctrl_fsm u_fsm (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .ctrl_we_i(ctrl_we_i),
        .run_wr_i (ctrl_wdata_i[BIT_RUN]),
        .ie_wr_i  (ie_wr),
        .state_o  (state),
        .flush_o  (flush),
        .accept_o (accept),
        .ie_o     (ie)
    );

    assign run = (state == ST_RUN);

    fsi_fifo #(.DEPTH(DEPTH), .WIDTH(DW)) u_tx_fifo (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (flush),
        .push_i (accept && tx_push_i),
        .din_i  (tx_data_i),
        .pop_i  (accept && eng_tx_take_i),
        .head_o (tx_head),
        .count_o(tx_cnt)
    );

    fsi_fifo #(.DEPTH(DEPTH), .WIDTH(DW)) u_rx_fifo (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (flush),
        .push_i (accept && eng_rx_valid_i),
        .din_i  (eng_rx_data_i),
        .pop_i  (accept && rx_pop_i),
        .head_o (rx_head),
        .count_o(rx_cnt)
    );

    fsi_flags #(.DEPTH(DEPTH)) u_flags (
        .tx_count_i(tx_cnt),
        .rx_count_i(rx_cnt),
        .flags_o   (flags)
    );

    fsi_irq u_irq (
        .run_i  (run),
        .ie_i   (ie),
        .flags_i(flags),
        .irq_o  (irq_o)
    );

    always_comb begin
        ctrl_rdata_o = '0;
        ctrl_rdata_o[BIT_RUN]      = run;
        ctrl_rdata_o[BIT_RX_AVAIL] = flags.rx_avail;
        ctrl_rdata_o[BIT_TX_EMPTY] = flags.tx_empty;
        ctrl_rdata_o[BIT_TX_BHALF] = flags.tx_below_half;
        ctrl_rdata_o[BIT_TX_FULL]  = flags.tx_full;
        ctrl_rdata_o[BIT_IE_LSB +: IE_W]        = ie;
        ctrl_rdata_o[DEPTH_LSB +: DEPTH_FLD_W]  = DEPTH_LOG;
    end

    assign rx_data_o      = rx_head;
    assign eng_tx_valid_o = run && !flags.tx_empty;
    assign eng_tx_data_o  = eng_tx_valid_o ? tx_head : '0;

endmodule

// File: rtl/fsi_checker.sv
module fsi_checker #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned DW    = 8
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          ctrl_we_i,
    input logic [31:0]   ctrl_wdata_i,
    input logic [31:0]   ctrl_rdata_o,
    input logic          tx_push_i,
    input logic          rx_pop_i,
    input logic [DW-1:0] rx_data_o,
    input logic          eng_tx_valid_o,
    input logic          eng_tx_take_i,
    input logic          eng_rx_valid_i,
    input logic          irq_o
);

    // R4: a full transmit FIFO stays full while nothing is taken
    p_full_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl_rdata_o[18] && !eng_tx_take_i && !ctrl_we_i |=> ctrl_rdata_o[18]);

    // R10: a stop write leaves both FIFOs empty and the request low
    p_flush_on_stop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl_we_i && !ctrl_wdata_i[0] |=> !ctrl_rdata_o[15] && ctrl_rdata_o[16] && !irq_o);

    // R6: the request needs an enabled, active condition
    p_irq_has_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> ctrl_rdata_o[0] && (|(ctrl_rdata_o[21:19] & ctrl_rdata_o[17:15])));

    // R6: with no traffic the request is held
    p_irq_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o && !ctrl_we_i && !tx_push_i && !rx_pop_i && !eng_rx_valid_i && !eng_tx_take_i
        |=> irq_o);

    // R7: an empty receive FIFO reads as zero
    p_rx_empty_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctrl_rdata_o[15] |-> rx_data_o == '0);

    // R2: an arrival while running makes data available
    p_rx_arrival_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl_rdata_o[0] && eng_rx_valid_i && !ctrl_we_i |=> ctrl_rdata_o[15]);

    // R9: offered transmit data implies a running, non-empty FIFO
    p_tx_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eng_tx_valid_o |-> ctrl_rdata_o[0] && !ctrl_rdata_o[16]);

    // R5: depth field
    p_depth_field_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl_rdata_o[26:23] == 4'($clog2(DEPTH)));

endmodule

bind fifo_stat_irq fsi_checker #(.DEPTH(DEPTH), .DW(DW)) u_fsi_checker (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ctrl_we_i     (ctrl_we_i),
    .ctrl_wdata_i  (ctrl_wdata_i),
    .ctrl_rdata_o  (ctrl_rdata_o),
    .tx_push_i     (tx_push_i),
    .rx_pop_i      (rx_pop_i),
    .rx_data_o     (rx_data_o),
    .eng_tx_valid_o(eng_tx_valid_o),
    .eng_tx_take_i (eng_tx_take_i),
    .eng_rx_valid_i(eng_rx_valid_i),
    .irq_o         (irq_o)
);

// File: tb/tb_fifo_stat_irq.sv
module tb_fifo_stat_irq;

    localparam int D    = 4;
    localparam int HALF = 2;
    localparam logic [31:0] DFLD = 32'(2) << 23;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic [31:0] ctrl_rdata;
    logic        tx_push = 1'b0;
    logic [7:0]  tx_data = '0;
    logic        rx_pop = 1'b0;
    logic [7:0]  rx_data;
    logic        tx_valid;
    logic [7:0]  tx_head;
    logic        tx_take = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_in = '0;
    logic        irq;

    always #10 clk = ~clk;

    fifo_stat_irq #(.DEPTH(D), .DW(8)) dut (
        .clk_i(clk), .rst_ni(rst_n),
        .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata), .ctrl_rdata_o(ctrl_rdata),
        .tx_push_i(tx_push), .tx_data_i(tx_data),
        .rx_pop_i(rx_pop), .rx_data_o(rx_data),
        .eng_tx_valid_o(tx_valid), .eng_tx_data_o(tx_head), .eng_tx_take_i(tx_take),
        .eng_rx_valid_i(rx_valid), .eng_rx_data_i(rx_in),
        .irq_o(irq)
    );

    // behavioural reference
    logic [7:0] m_tx[$];
    logic [7:0] m_rx[$];
    logic       m_run = 1'b0;
    logic [2:0] m_ie  = '0;

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        logic nrun;
        logic txp, txpop, rxp, rxpop;
        if (!rst_n) begin
            m_tx.delete(); m_rx.delete(); m_run = 1'b0; m_ie = '0;
            return;
        end
        nrun = ctrl_we ? ctrl_wdata[0] : m_run;
        if (ctrl_we) m_ie = ctrl_wdata[21:19];
        if (!nrun) begin
            m_tx.delete(); m_rx.delete();
        end else if (m_run) begin
            txp   = tx_push  && (m_tx.size() < D);
            txpop = tx_take  && (m_tx.size() > 0);
            rxp   = rx_valid && (m_rx.size() < D);
            rxpop = rx_pop   && (m_rx.size() > 0);
            if (txpop) void'(m_tx.pop_front());
            if (txp)   m_tx.push_back(tx_data);
            if (rxpop) void'(m_rx.pop_front());
            if (rxp)   m_rx.push_back(rx_in);
        end
        m_run = nrun;
    endtask

    task automatic compare();
        logic rxav, txe, txbh, txf, eirq;
        logic [31:0] w;
        rxav = m_rx.size() != 0;
        txe  = m_tx.size() == 0;
        txbh = m_tx.size() < HALF;
        txf  = m_tx.size() == D;
        eirq = m_run && ((m_ie[0] && rxav) || (m_ie[1] && txe) || (m_ie[2] && txbh));
        w = DFLD;
        w[0] = m_run; w[15] = rxav; w[16] = txe; w[17] = txbh; w[18] = txf;
        w[21:19] = m_ie;
        chk("R2 rx_avail", 32'(ctrl_rdata[15]), 32'(rxav));
        chk("R2 tx_empty", 32'(ctrl_rdata[16]), 32'(txe));
        chk("R3 tx_below_half", 32'(ctrl_rdata[17]), 32'(txbh));
        chk("R4 tx_full", 32'(ctrl_rdata[18]), 32'(txf));
        chk("R5 ctrl word", ctrl_rdata, w);
        chk("R6 irq", 32'(irq), 32'(eirq));
        chk("R7 rx_data", 32'(rx_data), rxav ? 32'(m_rx[0]) : 32'h0);
        chk("R9 tx_valid", 32'(tx_valid), 32'(m_run && !txe));
        if (m_run && !txe) chk("R9 tx_data", 32'(tx_head), 32'(m_tx[0]));
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        ctrl_we = 0; tx_push = 0; rx_pop = 0; tx_take = 0; rx_valid = 0;
    endtask

    task automatic wr_ctrl(input logic [31:0] v);
        idle(); ctrl_we = 1; ctrl_wdata = v; cycle(); idle();
    endtask

    task automatic push_tx(input logic [7:0] b);
        idle(); tx_push = 1; tx_data = b; cycle(); idle();
    endtask

    task automatic arrive(input logic [7:0] b);
        idle(); rx_valid = 1; rx_in = b; cycle(); idle();
    endtask

    task automatic pop_rx();
        idle(); rx_pop = 1; cycle(); idle();
    endtask

    task automatic take_tx();
        idle(); tx_take = 1; cycle(); idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        cycle(); cycle();
        rst_n = 1'b1;
        compare();
        // R1 reset state
        chk("R1 reset ctrl", ctrl_rdata, DFLD | 32'h0003_0000);
        chk("R1 reset irq", 32'(irq), 32'h0);

        // R10 traffic while off has no effect
        push_tx(8'h11);
        arrive(8'h22);
        chk("R10 off push ignored", 32'(ctrl_rdata[16]), 32'h1);
        chk("R10 off arrival ignored", 32'(ctrl_rdata[15]), 32'h0);

        // R11 enable write together with traffic: traffic ignored
        idle(); ctrl_we = 1; ctrl_wdata = 32'h1; tx_push = 1; tx_data = 8'h33;
        rx_valid = 1; rx_in = 8'h44; cycle(); idle();
        chk("R11 running", 32'(ctrl_rdata[0]), 32'h1);
        chk("R11 tx ignored on enable", 32'(ctrl_rdata[16]), 32'h1);
        chk("R11 rx ignored on enable", 32'(ctrl_rdata[15]), 32'h0);

        // R3/R4 fill transmit FIFO
        push_tx(8'hA1);
        chk("R3 count1 below half", 32'(ctrl_rdata[17]), 32'h1);
        push_tx(8'hA2);
        chk("R3 count2 not below half", 32'(ctrl_rdata[17]), 32'h0);
        push_tx(8'hA3);
        push_tx(8'hA4);
        push_tx(8'hA5);
        chk("R4 drop when full", 32'(tx_head), 32'hA1);
        // R4 push with take while full: push dropped
        idle(); tx_take = 1; tx_push = 1; tx_data = 8'hA6; cycle(); idle();
        chk("R4 push on full+take dropped", 32'(ctrl_rdata[18]), 32'h0);
        for (int i = 0; i < 4; i++) take_tx();
        chk("R9 drained", 32'(tx_valid), 32'h0);
        take_tx();

        // R8 receive overflow, R7 order and empty pop
        for (int i = 0; i < 5; i++) arrive(8'(8'hB0 + i));
        chk("R8 overflow keeps oldest", 32'(rx_data), 32'hB0);
        idle(); rx_pop = 1; rx_valid = 1; rx_in = 8'hCC; cycle(); idle();
        for (int i = 0; i < 3; i++) pop_rx();
        chk("R8 arrival during full pop discarded", 32'(ctrl_rdata[15]), 32'h0);
        pop_rx();
        chk("R7 empty pop zero", 32'(rx_data), 32'h0);

        // R6 each enable on its own
        wr_ctrl(32'h1 | (32'h1 << 19));
        chk("R6 rx enable no data", 32'(irq), 32'h0);
        arrive(8'h5A);
        repeat (3) begin idle(); cycle(); end
        chk("R6 level held", 32'(irq), 32'h1);
        pop_rx();
        chk("R6 cleared by cause", 32'(irq), 32'h0);
        wr_ctrl(32'h1 | (32'h1 << 20));
        chk("R6 tx empty cause", 32'(irq), 32'h1);
        push_tx(8'h01);
        wr_ctrl(32'h1 | (32'h1 << 21));
        chk("R6 below half cause", 32'(irq), 32'h1);
        push_tx(8'h02);
        chk("R6 half reached", 32'(irq), 32'h0);

        // R10 stop with data in both FIFOs
        arrive(8'h77);
        wr_ctrl(32'h0038_0000);
        chk("R10 flush tx", 32'(ctrl_rdata[16]), 32'h1);
        chk("R10 flush rx", 32'(ctrl_rdata[15]), 32'h0);
        chk("R10 irq masked", 32'(irq), 32'h0);
        arrive(8'h78);
        pop_rx();
        take_tx();

        // restart, take on empty with push
        wr_ctrl(32'h1);
        idle(); tx_take = 1; tx_push = 1; tx_data = 8'h9E; cycle(); idle();
        chk("R9 push with empty take", 32'(tx_head), 32'h9E);
        repeat (3) begin idle(); cycle(); end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule